// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is a single DMA channel steered by a 24-bit control word. Software sets up a block count, a line length and the source and destination addresses through a small register port, then arms or launches the channel by setting the enable bit. The channel copies words one at a time. Each word is a read from the source address followed by a write to the destination address, both through a request/grant memory port. After every word, both addresses step up by one.

The transfer mode field picks two things: what starts a transfer, and how much is moved per start. A transfer is started either by the enable bit itself or by rising edges on a selected peripheral request line. Each start moves a whole block, one line or one word. A block-length counter reloads its preset when the block ends. In some modes the enable bit stays set so the channel remains armed; in others the hardware clears it.

An interrupt line signals block completion, and also signals a software stop of an active transfer. It stays raised until the service routine pulses an acknowledge input. The priority, continuous, three-dimensional, address-mode and memory-space fields are stored and read back but do not change the channel's behaviour.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, all five registers read zero, and `irq` and `mem_req` are low.
- R2: A write with `reg_wr` high updates the register chosen by `reg_sel` (0 control, 1 block count, 2 line length, 3 source address, 4 destination address). `reg_rdata` shows the register selected in the previous cycle. Reading select 1 returns the working counter.
- R3: The control word holds the enable bit at [23], the interrupt enable at [22] and the mode at [21:19]. With mode 100, setting the enable bit starts one full block at once with no request.
- R4: In every other mode, the enable bit only arms the channel. Control field [15:11] selects which `dreq` input is the request source. A rising edge on the selected input starts one unit of transfer. Edges on the other inputs, and edges while the channel is disarmed, start nothing.
- R5: The unit of transfer per start is as follows. Modes 000 and 100 move a block. Modes 001 and 101 move one word. Modes 010 and 110 move one line. Codes 011 and 111 behave as 000.
- R6: When a block ends, the hardware clears the enable bit in modes 000, 001, 010 and 100. In modes 101 and 110 the enable bit stays set.
- R7: A block is preset+1 words and a line is line length+1 words. A line also ends early if the block ends first. When the block ends, the working counter reloads the preset.
- R8: Each word is one read handshake followed by one write handshake. A handshake completes on the clock edge where `mem_req` and `mem_gnt` are both high. The read data is taken from `mem_rdata` in that cycle. `mem_req`, `mem_we` and `mem_addr` hold steady until the grant arrives. Both addresses post-increment by one after every word.
- R9: With the interrupt enable set, `irq` rises on the clock edge that completes the last write of a block. On that same edge the counter holds its reloaded preset.
- R10: If software clears the enable bit while a transfer is active, the word in flight is still read and written, and then the channel stops. If the interrupt enable is set when the channel stops, `irq` is raised.
- R11: Once raised, `irq` stays high until `irq_ack` is pulsed, even if the interrupt enable is cleared in the meantime.
- R12: Request edges that arrive while a transfer is active are dropped and do not start a later transfer.
- R13: Control bits [18:16] and [10:0] read back as written and have no effect. Addressing is always a post-increment of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Registered read data of the previously selected register |
| dreq | input | NREQ | Peripheral request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with the read grant |
| mem_gnt | input | 1 | Grant; completes the pending access |
| irq | output | 1 | Latched interrupt request |
| irq_ack | input | 1 | Interrupt service acknowledge |

## Verification
The assertions assume the following about the environment:
- `mem_gnt` is only meaningful while `mem_req` is high.
- `mem_rdata` is valid in the cycle of a read grant.
- Software does not rewrite the count, line or address registers while a transfer is active.

The stimulus follows these rules. Grants come from a memory model that answers only pending requests, on every third cycle, so that accesses are held for several cycles. Register writes during a transfer touch only the control word.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_W = 24;

  // control word bit positions
  localparam int EN_BIT   = 23;
  localparam int IE_BIT   = 22;
  localparam int MODE_HI  = 21;
  localparam int MODE_LO  = 19;
  localparam int RSEL_HI  = 15;
  localparam int RSEL_LO  = 11;

  // register select codes
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_LINE  = 3'd2;
  localparam logic [2:0] SEL_SRC   = 3'd3;
  localparam logic [2:0] SEL_DST   = 3'd4;

  typedef enum logic [1:0] {GR_BLOCK, GR_LINE, GR_WORD} gran_t;

  typedef struct packed {
    logic  by_enable;
    gran_t gran;
    logic  keep_en;
  } mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_t;

  function automatic mode_t decode_mode(input logic [2:0] m);
    mode_t d;
    case (m)
      3'b001:  d = '{by_enable: 1'b0, gran: GR_WORD,  keep_en: 1'b0};
      3'b010:  d = '{by_enable: 1'b0, gran: GR_LINE,  keep_en: 1'b0};
      3'b100:  d = '{by_enable: 1'b1, gran: GR_BLOCK, keep_en: 1'b0};
      3'b101:  d = '{by_enable: 1'b0, gran: GR_WORD,  keep_en: 1'b1};
      3'b110:  d = '{by_enable: 1'b0, gran: GR_LINE,  keep_en: 1'b1};
      default: d = '{by_enable: 1'b0, gran: GR_BLOCK, keep_en: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_clr_en,
  input  logic             irq_set,
  input  logic             irq_ack,
  output logic [REG_W-1:0] ctrl,
  output logic             sw_en_clear,
  output logic             irq
);

  logic ctrl_wr;
  assign ctrl_wr     = wr_en && (wr_sel == SEL_CTRL);
  assign sw_en_clear = ctrl_wr && ctrl[EN_BIT] && !wr_data[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (hw_clr_en) ctrl[EN_BIT] <= 1'b0;
      if (ctrl_wr)   ctrl <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end

  // R11: a pending interrupt only drops on acknowledge
  a_r11_irq_held: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_ack |=> irq);

endmodule

// File: rtl/dma_req_edge.sv
module dma_req_edge #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_in,
  input  logic [4:0]      sel,
  output logic            edge_o
);

  logic picked, q1, q2;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (sel == 5'(i)) picked = req_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= picked;
      q2 <= q1;
    end
  end

  assign edge_o = q1 && !q2;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sw_en_clear,
  input  mode_t             mode_i,
  input  logic              req_edge,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  line_len,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              block_end_evt,
  output logic              abort_evt,
  output logic              hw_clr_en
);

  xfer_st_t         st;
  logic [CNT_W-1:0] preset, line_cnt;
  logic             stop_pend;
  logic             start, word_end, last, halt;

  assign busy     = (st != ST_IDLE);
  assign start    = (st == ST_IDLE) && en && (mode_i.by_enable || req_edge);
  assign word_end = (st == ST_WR) && mem_gnt;

  assign block_end_evt = word_end && (cnt == '0);
  always_comb begin
    case (mode_i.gran)
      GR_WORD: last = 1'b1;
      GR_LINE: last = (line_cnt == '0) || (cnt == '0);
      default: last = (cnt == '0);
    endcase
  end
  assign halt      = last || stop_pend || sw_en_clear;
  assign abort_evt = word_end && (stop_pend || sw_en_clear);
  assign hw_clr_en = block_end_evt && !mode_i.keep_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cnt       <= '0;
      preset    <= '0;
      line_len  <= '0;
      line_cnt  <= '0;
      src       <= '0;
      dst       <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_RD;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src;
          line_cnt <= line_len;
        end
        ST_RD: if (mem_gnt) begin
          st        <= ST_WR;
          mem_wdata <= mem_rdata;
          mem_we    <= 1'b1;
          mem_addr  <= dst;
        end
        default: if (mem_gnt) begin
          src      <= src + 1'b1;
          dst      <= dst + 1'b1;
          cnt      <= (cnt == '0) ? preset : cnt - 1'b1;
          line_cnt <= (line_cnt == '0) ? line_len : line_cnt - 1'b1;
          mem_we   <= 1'b0;
          if (halt) begin
            st      <= ST_IDLE;
            mem_req <= 1'b0;
          end else begin
            st       <= ST_RD;
            mem_addr <= src + 1'b1;
          end
        end
      endcase

      if (word_end)                stop_pend <= 1'b0;
      else if (sw_en_clear && busy) stop_pend <= 1'b1;

      if (wr_en) begin
        case (wr_sel)
          SEL_COUNT: begin
            preset <= wr_data[CNT_W-1:0];
            cnt    <= wr_data[CNT_W-1:0];
          end
          SEL_LINE: line_len <= wr_data[CNT_W-1:0];
          SEL_SRC:  src      <= wr_data;
          SEL_DST:  dst      <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R8: an ungranted access is held unchanged
  a_r8_hold_access: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8: a granted read is always followed by the write of that word
  a_r8_read_then_write: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt && !mem_we |=> mem_req && mem_we);

  // R10: the channel only goes quiet right after a granted write
  a_r10_stop_after_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_req && mem_we && mem_gnt));

  // R7: the block end reloads the counter with its preset
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    block_end_evt && !wr_en |=> cnt == preset);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int NREQ   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NREQ-1:0]   dreq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_gnt,
  output logic              irq,
  input  logic              irq_ack
);

  logic [REG_W-1:0]  ctrl;
  logic              sw_en_clear, hw_clr_en, irq_set;
  logic              req_edge, busy, block_end_evt, abort_evt;
  logic [CNT_W-1:0]  cnt, line_len;
  logic [ADDR_W-1:0] src, dst;
  mode_t             mode;

  assign mode    = decode_mode(ctrl[MODE_HI:MODE_LO]);
  assign irq_set = ctrl[IE_BIT] && (block_end_evt || abort_evt);

  dma_ctrl_regs u_regs (
    .clk, .rst,
    .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .hw_clr_en, .irq_set, .irq_ack,
    .ctrl, .sw_en_clear, .irq
  );

  dma_req_edge #(.NREQ(NREQ)) u_req (
    .clk, .rst, .req_in(dreq), .sel(ctrl[RSEL_HI:RSEL_LO]), .edge_o(req_edge)
  );

  dma_xfer_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk, .rst,
    .en(ctrl[EN_BIT]), .sw_en_clear, .mode_i(mode), .req_edge,
    .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata[ADDR_W-1:0]),
    .mem_gnt, .mem_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .busy, .cnt, .line_len, .src, .dst,
    .block_end_evt, .abort_evt, .hw_clr_en
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_sel)
        SEL_CTRL:  reg_rdata <= ctrl;
        SEL_COUNT: reg_rdata <= REG_W'(cnt);
        SEL_LINE:  reg_rdata <= REG_W'(line_len);
        SEL_SRC:   reg_rdata <= REG_W'(src);
        SEL_DST:   reg_rdata <= REG_W'(dst);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R6: keep-enabled modes are never disarmed by the hardware
  a_r6_keep_armed: assert property (@(posedge clk) disable iff (rst)
    ctrl[EN_BIT] && mode.keep_en && !(reg_wr && reg_sel == SEL_CTRL)
    |=> ctrl[EN_BIT]);

  // R9: a block end with interrupts enabled raises irq
  a_r9_irq_on_block: assert property (@(posedge clk) disable iff (rst)
    block_end_evt && ctrl[IE_BIT] |=> irq);

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  import dma_chan_pkg::*;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [23:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  dreq = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0, irq, irq_ack = 1'b0;
  logic [23:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0, wr_count = 0, gphase = 0;
  logic [23:0] mem [256];
  logic [23:0] exp_addr [$];
  logic [23:0] exp_data [$];
  logic [23:0] v;
  logic [23:0] cv;

  always #4 clk = ~clk;

  dma_chan_seq dut (
    .clk, .rst, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata, .dreq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_gnt,
    .irq, .irq_ack
  );

  function automatic logic [23:0] pat(input int a);
    return 24'h300000 + 24'(a * 37);
  endfunction

  function automatic logic [23:0] mk(input logic en, input logic ie,
      input logic [2:0] m, input logic [4:0] rs, input logic [13:0] misc);
    return {en, ie, m, misc[13:11], rs, misc[10:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: grants and memory model, compare each write
  always @(negedge clk) begin
    gphase = (gphase + 1) % 3;
    mem_gnt = mem_req && (gphase == 0);
    if (mem_req && mem_gnt && mem_we) begin
      wr_count++;
      if (exp_addr.size() == 0) chk(0, "R12 unexpected write", mem_addr, 0);
      else begin
        logic [23:0] ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(mem_addr == ea, "R8 write address", mem_addr, ea);
        chk(mem_wdata == ed, "R8 write data", mem_wdata, ed);
      end
      mem[mem_addr[7:0]] = mem_wdata;
    end
    mem_rdata = mem[mem_addr[7:0]];
  end

  task automatic expect_words(input int s, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_addr.push_back(24'(d + i));
      exp_data.push_back(pat(s + i));
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [23:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [23:0] d);
    @(negedge clk); reg_sel = s;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); dreq[i] = 1'b1;
    repeat (3) @(negedge clk);
    dreq[i] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wr_count < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int cntv, input int linev, input int s, input int d);
    wr(SEL_COUNT, 24'(cntv));
    wr(SEL_LINE, 24'(linev));
    wr(SEL_SRC, 24'(s));
    wr(SEL_DST, 24'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(!irq && !mem_req, "R1 irq/mem_req idle", {irq, mem_req}, 0);

    // R2: register readback
    wr(SEL_LINE, 24'h000ABC);
    rd(SEL_LINE, v);
    chk(v == 24'h000ABC, "R2 line length readback", v, 24'h000ABC);

    // R3 R13 R9 R7: enable-triggered block with inert fields set
    setup(3, 0, 'h00, 'h80);
    expect_words('h00, 'h80, 4);
    cv = mk(1, 1, 3'b100, 5'd0, 14'h3AAB);
    wr(SEL_CTRL, cv);
    wait_writes(4);
    chk(wr_count == 4, "R3 block length", wr_count, 4);
    rd(SEL_CTRL, v);
    chk(v == (cv & 24'h7FFFFF), "R13 inert fields readback", v, cv & 24'h7FFFFF);
    rd(SEL_COUNT, v);
    chk(v == 3, "R7 counter reload", v, 3);
    chk(irq == 1, "R9 irq at block end", irq, 1);
    rd(SEL_SRC, v);
    chk(v == 4, "R8 source post-increment", v, 4);
    rd(SEL_DST, v);
    chk(v == 'h84, "R8 destination post-increment", v, 'h84);

    // R11: irq held while interrupt enable cleared, drops on ack
    wr(SEL_CTRL, mk(0, 0, 3'b100, 5'd0, 14'h0));
    repeat (5) @(negedge clk);
    chk(irq == 1, "R11 irq held after enable clear", irq, 1);
    ack();
    chk(irq == 0, "R11 irq cleared by ack", irq, 0);

    // R4 R6: request-triggered block, mode 000, source 1
    setup(2, 0, 'h10, 'h90);
    wr(SEL_CTRL, mk(1, 0, 3'b000, 5'd1, 14'h0));
    repeat (12) @(negedge clk);
    chk(wr_count == 4 && !mem_req, "R4 armed only", wr_count, 4);
    expect_words('h10, 'h90, 3);
    pulse(1);
    wait_writes(7);
    rd(SEL_CTRL, v);
    chk(v[23] == 0, "R6 enable cleared mode 000", v[23], 0);
    chk(irq == 0, "R9 no irq without enable", irq, 0);

    // R5 R6 R4: word per request kept armed, source 2
    setup(1, 0, 'h20, 'hA0);
    wr(SEL_CTRL, mk(1, 1, 3'b101, 5'd2, 14'h0));
    pulse(0);
    repeat (15) @(negedge clk);
    chk(wr_count == 7, "R4 unselected line ignored", wr_count, 7);
    expect_words('h20, 'hA0, 2);
    pulse(2);
    wait_writes(8);
    repeat (10) @(negedge clk);
    chk(wr_count == 8, "R5 one word per request", wr_count, 8);
    chk(irq == 0, "R9 no irq mid block", irq, 0);
    pulse(2);
    wait_writes(9);
    chk(irq == 1, "R9 irq at word-mode block end", irq, 1);
    rd(SEL_CTRL, v);
    chk(v[23] == 1, "R6 enable kept mode 101", v[23], 1);
    ack();
    wr(SEL_CTRL, 24'h0);

    // R5 R7 R6: line per request, mode 010, two-word lines
    setup(3, 1, 'h30, 'hB0);
    wr(SEL_CTRL, mk(1, 1, 3'b010, 5'd3, 14'h0));
    expect_words('h30, 'hB0, 4);
    pulse(3);
    wait_writes(11);
    repeat (10) @(negedge clk);
    chk(wr_count == 11, "R7 line length", wr_count, 11);
    rd(SEL_CTRL, v);
    chk(v[23] == 1, "R6 enable held before block end", v[23], 1);
    pulse(3);
    wait_writes(13);
    rd(SEL_CTRL, v);
    chk(v[23] == 0, "R6 enable cleared mode 010", v[23], 0);
    chk(irq == 1, "R9 irq line-mode block end", irq, 1);
    ack();

    // R12: request edges during a line are dropped, mode 110
    setup(15, 3, 'h40, 'hC0);
    wr(SEL_CTRL, mk(1, 0, 3'b110, 5'd0, 14'h0));
    base = wr_count;
    expect_words('h40, 'hC0, 4);
    pulse(0);
    while (wr_count < base + 1) @(negedge clk);
    pulse(0);
    repeat (40) @(negedge clk);
    chk(wr_count == base + 4, "R12 busy edge dropped", wr_count, base + 4);
    expect_words('h44, 'hC4, 4);
    pulse(0);
    wait_writes(base + 8);
    repeat (20) @(negedge clk);
    chk(wr_count == base + 8, "R5 next line after idle", wr_count, base + 8);
    wr(SEL_CTRL, 24'h0);

    // R10: software stop finishes the word in flight
    setup(7, 0, 'h50, 'hD0);
    base = wr_count;
    expect_words('h50, 'hD0, 8);
    wr(SEL_CTRL, mk(1, 1, 3'b100, 5'd0, 14'h0));
    while (!(wr_count == base + 2 && mem_req && !mem_we)) @(negedge clk);
    wr(SEL_CTRL, mk(0, 1, 3'b100, 5'd0, 14'h0));
    repeat (40) @(negedge clk);
    chk(wr_count == base + 3, "R10 word in flight completed", wr_count, base + 3);
    chk(!mem_req, "R10 channel stopped", mem_req, 0);
    chk(irq == 1, "R10 irq on software stop", irq, 1);
    chk(exp_addr.size() == 5, "R10 remaining words skipped", exp_addr.size(), 5);
    exp_addr.delete();
    exp_data.delete();
    ack();

    // R5: undefined code 011 behaves as block per request
    setup(1, 0, 'h60, 'hE0);
    base = wr_count;
    wr(SEL_CTRL, mk(1, 0, 3'b011, 5'd0, 14'h0));
    expect_words('h60, 'hE0, 2);
    pulse(0);
    wait_writes(base + 2);
    repeat (10) @(negedge clk);
    chk(wr_count == base + 2, "R5 code 011 block", wr_count, base + 2);
    rd(SEL_CTRL, v);
    chk(v[23] == 0, "R5 code 011 disarms", v[23], 0);
    chk(exp_addr.size() == 0, "R8 all expected writes seen", exp_addr.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule